// File: doc/BRIEF.md
# Black-Level Offset Calibration Controller

This controller closes a digital loop around an image sensor's analog front end so that optically shielded pixels read back at a chosen target code. Each line carries a window of black pixels. The window starts when an active-low calibration strobe falls. The controller ignores the first three samples of the window, because they are latency padding. It then sums a programmable number of samples. After a programmable number of lines, it forms the average and removes the +255 pedestal that the front end adds during black pixels. It then compares the result with the target code.

The error is applied to two sign-magnitude offset words. The fine word acts after the gain stage and spans ±255 ADC LSB. When a correction would push the fine word past that span, the fine word saturates and the coarse word, which acts before the gain stage, moves one code toward the target. Each path can be frozen at a software-set value. A status view of the fine path can replace the sample stream on the data output.

Top module: `blk_cal_top`

## Requirements
- R1: After reset both offset words are zero (bit 8 = 0 sign, bits 7:0 = 0 magnitude), the range flag is 1 and the update strobe is 0.
- R2: A window opens on the first clock on which `cal_n` is low after being high. The samples on that clock and the next two are discarded. The following per-line count of samples is summed. Samples that arrive after that count, while `cal_n` stays low, are discarded.
- R3: The per-line count is 2^`n_sel`; an `n_sel` above 6 gives 64.
- R4: With `triple` set, the per-line count is 3·2^`n_sel` (3 to 192).
- R5: A set is 2^`l_sel` lines, with an `l_sel` above 8 giving 256. Exactly one one-cycle `upd` pulse follows each completed set. Outside that pulse, the offset words do not change while their paths are automatic.
- R6: At an update the black level is floor(sum / samples in the set) − 255, and the fine value becomes the fine value plus (`target` − black level).
- R7: Offset words are sign-magnitude. Bit 8 is the sign (1 = negative) and bits 7:0 are the magnitude.
- R8: If the new fine value exceeds +255 or falls below −255, the fine word saturates at that limit, the coarse word steps by exactly one in the same direction, and the flag goes to 0. Otherwise the flag is 1 and the coarse word is unchanged.
- R9: With `fine_byp` set, both words equal `fine_reg` and `coarse_reg` and updates leave them unchanged. With only `coarse_byp` set, the coarse word equals `coarse_reg` while the fine word stays automatic and still saturates.
- R10: When a path returns to automatic mode, its next update starts from the register value it showed while bypassed.
- R11: A `clr` pulse discards the partial sum and the line count, and the set restarts with the next window.
- R12: With `out_sel[1]` = 1, `dout` = {flag, fine word} (bit 9 the flag, bit 8 the sign, bits 7:0 the magnitude). Otherwise `dout` passes `adc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_n | input | 1 | Active-low black-window strobe |
| adc | input | 10 | ADC sample |
| n_sel | input | 3 | Per-line pixel exponent |
| l_sel | input | 4 | Line-count exponent |
| triple | input | 1 | Triples the per-line pixel count |
| target | input | 10 | Target black code |
| coarse_byp | input | 1 | Freeze coarse word at coarse_reg |
| fine_byp | input | 1 | Freeze both words at their registers |
| coarse_reg | input | 9 | Programmed coarse word |
| fine_reg | input | 9 | Programmed fine word |
| clr | input | 1 | Discard partial black-level sum |
| out_sel | input | 2 | Data output select |
| coarse_w | output | 9 | Coarse offset word |
| fine_w | output | 9 | Fine offset word |
| flag | output | 1 | 1 = last correction fit the fine range |
| upd | output | 1 | One-cycle pulse when words update |
| dout | output | 10 | Sample or status word |

## Verification
The bench fills the padding slots and the post-window slots with 1023 and 0. A design that summed them, or that miscounted 2^N, 3·2^N or the clamped exponents, produces a fine word that misses the model. A positive and a negative overflow each check that the fine word saturates, that the coarse word moves by one in the correct direction and that the flag drops. A design that let the fine word wrap would show a small magnitude with the wrong sign. The bench also bypasses the paths, re-enables them and pulses `clr` in the middle of a set. A design that kept stale internal words or a stale partial sum would disagree with the expected words at the next update.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int MAG_W  = 8;
  localparam int WORD_W = MAG_W + 1;
  localparam int SW     = 14;

  typedef enum logic [1:0] {W_IDLE, W_PAD, W_ACC, W_WAIT} win_st_t;

  function automatic logic signed [SW-1:0] sm2s(input logic [WORD_W-1:0] w);
    logic signed [SW-1:0] m;
    m = $signed(SW'(w[MAG_W-1:0]));
    return w[MAG_W] ? -m : m;
  endfunction

  function automatic logic [WORD_W-1:0] s2sm(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] a;
    a = (v < 0) ? -v : v;
    return {(v < 0), a[MAG_W-1:0]};
  endfunction
endpackage

// File: rtl/blc_window.sv
module blc_window import blc_pkg::*; #(
  parameter int DW = 10,
  parameter int PX = 6,
  parameter int LX = 8,
  localparam int NSW   = $clog2(PX + 1),
  localparam int LSW   = $clog2(LX + 1),
  localparam int PCW   = PX + 2,
  localparam int LCW   = LX + 1,
  localparam int ACC_W = DW + PCW + LX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_n,
  input  logic [DW-1:0]    adc,
  input  logic [NSW-1:0]   n_eff,
  input  logic [LSW-1:0]   l_eff,
  input  logic             triple,
  input  logic             clr,
  output logic [ACC_W-1:0] acc,
  output logic             set_done
);
  win_st_t st_q, st_d;
  logic [PCW-1:0] cnt_q, cnt_d, pix_last;
  logic [LCW-1:0] ln_q, ln_d, line_last;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic prev_q, done_q, done_d;

  assign pix_last  = triple ? PCW'((3 << n_eff) - 1) : PCW'((1 << n_eff) - 1);
  assign line_last = LCW'((1 << l_eff) - 1);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; ln_d = ln_q; acc_d = acc_q; done_d = 1'b0;
    if (clr) begin
      st_d = W_WAIT; ln_d = '0; acc_d = '0;
    end else begin
      case (st_q)
        W_IDLE: if (!cal_n && prev_q) begin
          st_d  = W_PAD;
          cnt_d = PCW'(1);
          if (ln_q == '0) acc_d = '0;
        end
        W_PAD: begin
          cnt_d = cnt_q + PCW'(1);
          if (cnt_q == PCW'(2)) begin st_d = W_ACC; cnt_d = '0; end
        end
        W_ACC: begin
          acc_d = acc_q + ACC_W'(adc);
          cnt_d = cnt_q + PCW'(1);
          if (cnt_q == pix_last) begin
            st_d = W_WAIT;
            if (ln_q == line_last) begin ln_d = '0; done_d = 1'b1; end
            else ln_d = ln_q + LCW'(1);
          end
        end
        default: if (cal_n) st_d = W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; cnt_q <= '0; ln_q <= '0; acc_q <= '0;
      prev_q <= 1'b1; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; ln_q <= ln_d; acc_q <= acc_d;
      prev_q <= cal_n; done_q <= done_d;
    end
  end

  assign acc      = acc_q;
  assign set_done = done_q;
endmodule

// File: rtl/blc_avg.sv
module blc_avg #(
  parameter int ACC_W = 26,
  parameter int AVG_W = 12,
  parameter int NSW   = 3,
  parameter int LSW   = 4,
  localparam int STW  = $clog2(AVG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ACC_W-1:0] acc,
  input  logic [NSW-1:0]   n_eff,
  input  logic [LSW-1:0]   l_eff,
  input  logic             triple,
  output logic [AVG_W-1:0] avg,
  output logic             valid
);
  logic [AVG_W-1:0] q_q, q_d;
  logic [1:0] rem_q, rem_d;
  logic [STW-1:0] step_q, step_d;
  logic busy_q, busy_d, vld_q, vld_d, run_en;
  logic [2:0] trial;
  logic [ACC_W-1:0] shifted;

  assign shifted = acc >> (int'(n_eff) + int'(l_eff));
  assign trial   = {rem_q, q_q[AVG_W-1]};
  assign run_en  = start || busy_q;

  always_comb begin
    q_d = q_q; rem_d = rem_q; step_d = step_q; busy_d = busy_q; vld_d = 1'b0;
    if (start) begin
      q_d = AVG_W'(shifted); rem_d = '0; step_d = '0;
      busy_d = triple; vld_d = !triple;
    end else if (busy_q) begin
      if (trial >= 3'd3) begin
        rem_d = 2'(trial - 3'd3);
        q_d   = {q_q[AVG_W-2:0], 1'b1};
      end else begin
        rem_d = trial[1:0];
        q_d   = {q_q[AVG_W-2:0], 1'b0};
      end
      step_d = step_q + STW'(1);
      if (step_q == STW'(AVG_W - 1)) begin busy_d = 1'b0; vld_d = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0; rem_q <= '0; step_q <= '0; busy_q <= 1'b0; vld_q <= 1'b0;
    end else begin
      if (run_en) begin
        q_q <= q_d; rem_q <= rem_d; step_q <= step_d; busy_q <= busy_d;
      end
      vld_q <= vld_d;
    end
  end

  assign avg   = q_q;
  assign valid = vld_q;
endmodule

// File: rtl/blc_update.sv
module blc_update import blc_pkg::*; #(
  parameter int DW    = 10,
  parameter int AVG_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [AVG_W-1:0]  avg,
  input  logic [DW-1:0]     target,
  input  logic              coarse_byp,
  input  logic              fine_byp,
  input  logic [WORD_W-1:0] coarse_reg,
  input  logic [WORD_W-1:0] fine_reg,
  output logic [WORD_W-1:0] coarse_w,
  output logic [WORD_W-1:0] fine_w,
  output logic              flag,
  output logic              upd
);
  localparam logic signed [SW-1:0] LIM = SW'((2 ** MAG_W) - 1);
  localparam logic signed [SW-1:0] PED = SW'(255);
  localparam logic signed [SW-1:0] ONE = SW'(1);

  logic [WORD_W-1:0] fine_q, fine_d, coarse_q, coarse_d;
  logic flag_q, flag_d, upd_q;
  logic fine_auto, coarse_auto;
  logic signed [SW-1:0] corr, f_sum, c_sum, step;

  assign fine_auto   = !fine_byp;
  assign coarse_auto = !fine_byp && !coarse_byp;
  assign corr  = $signed(SW'(target)) - $signed(SW'(avg)) + PED;
  assign f_sum = sm2s(fine_q) + corr;

  always_comb begin
    fine_d = fine_q; coarse_d = coarse_q; flag_d = flag_q; step = '0;
    c_sum = sm2s(coarse_q);
    if (!fine_auto)   fine_d   = fine_reg;
    if (!coarse_auto) coarse_d = coarse_reg;
    if (valid && fine_auto) begin
      if (f_sum > LIM) begin
        fine_d = s2sm(LIM); step = ONE;
      end else if (f_sum < -LIM) begin
        fine_d = s2sm(-LIM); step = -ONE;
      end else begin
        fine_d = s2sm(f_sum);
      end
      flag_d = (step == '0);
      c_sum  = sm2s(coarse_q) + step;
      if (coarse_auto && step != '0)
        coarse_d = s2sm((c_sum > LIM) ? LIM : ((c_sum < -LIM) ? -LIM : c_sum));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q <= '0; coarse_q <= '0; flag_q <= 1'b1; upd_q <= 1'b0;
    end else begin
      fine_q <= fine_d; coarse_q <= coarse_d; flag_q <= flag_d; upd_q <= valid;
    end
  end

  assign fine_w   = fine_auto   ? fine_q   : fine_reg;
  assign coarse_w = coarse_auto ? coarse_q : coarse_reg;
  assign flag     = flag_q;
  assign upd      = upd_q;
endmodule

// File: rtl/blk_cal_top.sv
module blk_cal_top import blc_pkg::*; #(
  parameter int DW = 10,
  parameter int PX = 6,
  parameter int LX = 8,
  localparam int NSW   = $clog2(PX + 1),
  localparam int LSW   = $clog2(LX + 1),
  localparam int ACC_W = DW + PX + 2 + LX,
  localparam int AVG_W = DW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_n,
  input  logic [DW-1:0]     adc,
  input  logic [NSW-1:0]    n_sel,
  input  logic [LSW-1:0]    l_sel,
  input  logic              triple,
  input  logic [DW-1:0]     target,
  input  logic              coarse_byp,
  input  logic              fine_byp,
  input  logic [WORD_W-1:0] coarse_reg,
  input  logic [WORD_W-1:0] fine_reg,
  input  logic              clr,
  input  logic [1:0]        out_sel,
  output logic [WORD_W-1:0] coarse_w,
  output logic [WORD_W-1:0] fine_w,
  output logic              flag,
  output logic              upd,
  output logic [DW-1:0]     dout
);
  logic [1:0] rs_q;
  logic srst_n, set_done, avg_vld;
  logic [NSW-1:0] n_eff;
  logic [LSW-1:0] l_eff;
  logic [ACC_W-1:0] acc;
  logic [AVG_W-1:0] avg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign n_eff = (n_sel > NSW'(PX)) ? NSW'(PX) : n_sel;
  assign l_eff = (l_sel > LSW'(LX)) ? LSW'(LX) : l_sel;

  blc_window #(.DW(DW), .PX(PX), .LX(LX)) u_win (
    .clk(clk), .rst_n(srst_n), .cal_n(cal_n), .adc(adc), .n_eff(n_eff),
    .l_eff(l_eff), .triple(triple), .clr(clr), .acc(acc), .set_done(set_done));

  blc_avg #(.ACC_W(ACC_W), .AVG_W(AVG_W), .NSW(NSW), .LSW(LSW)) u_avg (
    .clk(clk), .rst_n(srst_n), .start(set_done), .acc(acc), .n_eff(n_eff),
    .l_eff(l_eff), .triple(triple), .avg(avg), .valid(avg_vld));

  blc_update #(.DW(DW), .AVG_W(AVG_W)) u_upd (
    .clk(clk), .rst_n(srst_n), .valid(avg_vld), .avg(avg), .target(target),
    .coarse_byp(coarse_byp), .fine_byp(fine_byp), .coarse_reg(coarse_reg),
    .fine_reg(fine_reg), .coarse_w(coarse_w), .fine_w(fine_w), .flag(flag),
    .upd(upd));

  assign dout = out_sel[1] ? DW'({flag, fine_w}) : adc;
endmodule

// File: rtl/blc_chk.sv
module blc_chk import blc_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              upd,
  input logic              flag,
  input logic              fine_byp,
  input logic              coarse_byp,
  input logic [WORD_W-1:0] coarse_w,
  input logic [WORD_W-1:0] fine_w,
  input logic [WORD_W-1:0] coarse_reg
);
  // R5
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R5
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !fine_byp && !$past(fine_byp)) |-> $stable(fine_w));

  // R8
  coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fine_byp && !coarse_byp && !$past(fine_byp) && !$past(coarse_byp)) |->
      ((sm2s(coarse_w) - sm2s($past(coarse_w)) <= 1) &&
       (sm2s(coarse_w) - sm2s($past(coarse_w)) >= -1)));

  // R8
  fine_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !flag && !fine_byp) |-> (fine_w[MAG_W-1:0] == '1));

  // R9
  byp_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_byp |-> (coarse_w == coarse_reg));
endmodule

bind blk_cal_top blc_chk u_chk (
  .clk(clk), .rst_n(srst_n), .upd(upd), .flag(flag), .fine_byp(fine_byp),
  .coarse_byp(coarse_byp), .coarse_w(coarse_w), .fine_w(fine_w),
  .coarse_reg(coarse_reg));

// File: tb/tb_blk_cal_top.sv
module tb_blk_cal_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, cal_n = 1'b1;
  logic [9:0] adc = '0, target = 10'h040;
  logic [2:0] n_sel = 3'd3;
  logic [3:0] l_sel = '0;
  logic triple = 1'b0, coarse_byp = 1'b0, fine_byp = 1'b0, clr = 1'b0;
  logic [8:0] coarse_reg = '0, fine_reg = '0;
  logic [1:0] out_sel = '0;
  logic [8:0] coarse_w, fine_w;
  logic flag, upd;
  logic [9:0] dout;

  blk_cal_top dut (.clk(clk), .rst_n(rst_n), .cal_n(cal_n), .adc(adc),
    .n_sel(n_sel), .l_sel(l_sel), .triple(triple), .target(target),
    .coarse_byp(coarse_byp), .fine_byp(fine_byp), .coarse_reg(coarse_reg),
    .fine_reg(fine_reg), .clr(clr), .out_sel(out_sel), .coarse_w(coarse_w),
    .fine_w(fine_w), .flag(flag), .upd(upd), .dout(dout));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  int m_fine = 0, m_coarse = 0;
  logic m_flag = 1'b1;
  logic [18:0] expq[$];
  string tagq[$];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [8:0] enc(int v);
    return {(v < 0), 8'((v < 0) ? -v : v)};
  endfunction

  function automatic int dec(logic [8:0] w);
    return w[8] ? -int'(w[7:0]) : int'(w[7:0]);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected update", 1, 0);
      else begin
        logic [18:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(coarse_w == e[18:10], {t, " coarse"}, int'(coarse_w), int'(e[18:10]));
        chk(fine_w == e[9:1], {t, " fine"}, int'(fine_w), int'(e[9:1]));
        chk(flag == e[0], {t, " flag"}, int'(flag), int'(e[0]));
      end
    end
  end

  task automatic drive_line(int v, int step, int p, output longint s);
    s = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cal_n = 1'b0; adc = (k % 2 == 0) ? 10'd1023 : 10'd0;
    end
    for (int i = 0; i < p; i++) begin
      @(negedge clk); adc = 10'(v + i * step); s += v + i * step;
    end
  endtask

  task automatic line_tail();
    @(negedge clk); adc = 10'd1023;
    @(negedge clk); adc = 10'd0;
    @(negedge clk); cal_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cal_set(int ns, int ls, bit tr, int base, int step, int lstep, string tag);
    int np, nl, p, lines, avg, corr, nf, ovf;
    longint sum, s;
    n_sel = 3'(ns); l_sel = 4'(ls); triple = tr;
    np = (ns > 6) ? 6 : ns;
    nl = (ls > 8) ? 8 : ls;
    p = (tr ? 3 : 1) << np;
    lines = 1 << nl;
    sum = 0;
    for (int ln = 0; ln < lines; ln++) begin
      drive_line(base + (ln % 4) * lstep, step, p, s);
      sum += s;
      if (ln == lines - 1) begin
        avg = int'(sum / longint'(p * lines));
        corr = int'(target) - (avg - 255);
        if (!fine_byp) begin
          nf = m_fine + corr; ovf = 0;
          if (nf > 255) begin m_fine = 255; ovf = 1; end
          else if (nf < -255) begin m_fine = -255; ovf = -1; end
          else m_fine = nf;
          m_flag = (ovf == 0);
          if (!coarse_byp && ovf != 0) begin
            m_coarse += ovf;
            if (m_coarse > 255) m_coarse = 255;
            if (m_coarse < -255) m_coarse = -255;
          end
        end else begin
          m_fine = dec(fine_reg); m_coarse = dec(coarse_reg);
        end
        if (coarse_byp) m_coarse = dec(coarse_reg);
        expq.push_back({enc(m_coarse), enc(m_fine), m_flag});
        tagq.push_back(tag);
      end
      line_tail();
    end
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(coarse_w == 9'd0, "R1 coarse", int'(coarse_w), 0);
    chk(fine_w == 9'd0, "R1 fine", int'(fine_w), 0);
    chk(flag == 1'b1, "R1 flag", int'(flag), 1);
    chk(upd == 1'b0, "R1 upd", int'(upd), 0);
    // R12 pass-through
    adc = 10'h155; out_sel = 2'b01; #1;
    chk(dout == 10'h155, "R12 passthrough", int'(dout), 'h155);
    out_sel = 2'b00; adc = '0;
    // R2 R6 default count, zero error then offset error
    cal_set(3, 0, 0, 319, 0, 0, "R2 R6");
    cal_set(3, 0, 0, 329, 0, 0, "R6 R7");
    // R3 multi-line, R5 line count
    cal_set(2, 2, 0, 300, 3, 5, "R5");
    // R4 triple
    cal_set(1, 1, 1, 280, 7, 2, "R4");
    // R3 clamp of pixel exponent
    cal_set(7, 0, 0, 250, 1, 0, "R3");
    // R5 clamp of line exponent
    cal_set(0, 9, 0, 300, 0, 3, "R5 clamp");
    // R8 negative overflow
    cal_set(0, 0, 0, 1000, 0, 0, "R8 neg");
    // R12 status view
    out_sel = 2'b10; #1;
    chk(dout == {m_flag, enc(m_fine)}, "R12 status", int'(dout), int'({m_flag, enc(m_fine)}));
    out_sel = 2'b00;
    // R8 positive overflow
    target = 10'd1023;
    cal_set(0, 0, 0, 0, 0, 0, "R8 pos");
    target = 10'h040;
    // R9 full bypass
    fine_reg = {1'b1, 8'd20}; coarse_reg = {1'b0, 8'd3}; fine_byp = 1'b1;
    repeat (2) @(negedge clk);
    chk(fine_w == fine_reg, "R9 fine bypass", int'(fine_w), int'(fine_reg));
    chk(coarse_w == coarse_reg, "R9 coarse bypass", int'(coarse_w), int'(coarse_reg));
    cal_set(0, 0, 0, 500, 0, 0, "R9 frozen");
    // R10 fine resumes from register, coarse still bypassed
    coarse_byp = 1'b1; fine_byp = 1'b0;
    m_fine = dec(fine_reg); m_coarse = dec(coarse_reg);
    @(negedge clk);
    cal_set(0, 0, 0, 324, 0, 0, "R10");
    cal_set(0, 0, 0, 1000, 0, 0, "R9 coarse held");
    // R10 coarse resumes from register
    coarse_byp = 1'b0;
    @(negedge clk);
    cal_set(0, 0, 0, 700, 0, 0, "R10 coarse");
    // R11 clear drops a partial set
    n_sel = 3'd0; l_sel = 4'd1; triple = 1'b0;
    drive_line(900, 0, 1, dummy);
    line_tail();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (3) @(negedge clk);
    cal_set(0, 1, 0, 330, 0, 0, "R11");
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule